// File: doc/BRIEF.md
# Masked Round-Robin Index Counter

This block holds a slot index between 0 and N-1 and moves it around a ring of N positions. On each clock edge where advancing is enabled, the index jumps to the closest marked position that follows the current one. A position is marked when its bit in an N-bit mask input is 1. The search wraps from N-1 back to 0. The current position is checked last, so when it is the only marked bit the index stays where it is.

The mask may change on any cycle. Each step reads only the mask present at that clock edge, so the order of visited positions follows the mask as it changes. When the mask is all zero, the index holds its value. A combinational flag shows whether any position is marked. The whole search happens within one cycle: the mask is rotated so the position after the current one comes first, the lowest set bit of the rotated mask is found, and that offset is mapped back to an absolute index.

Top module: `rr_mask_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the index to 0. Reset takes priority over advancing in the same cycle, whatever the mask holds.
- R2: When adv is low at a rising edge, the index keeps its value whatever the mask holds.
- R3: When adv is high and the mask is nonzero, the index becomes the smallest k in 1..N whose position (idx+k) mod N has its mask bit at 1, where mask bit i stands for position i.
- R4: Unmarked positions are skipped. For example, with N=8, index 2 and mask 8'h22 (bits 1 and 5 set), the next index is 5.
- R5: The search wraps past N-1 to 0. For example, from index 5 with mask 8'h22 the next index is 1, and from 7 with mask 8'h01 it is 0.
- R6: The current position is the last candidate. If its bit is the only one set, an advance leaves the index unchanged.
- R7: When adv is high and the mask is all zero, the index holds its value.
- R8: valid is combinational and equals 1 exactly when at least one mask bit is 1.
- R9: Each advance uses only the mask present at that edge, so a mask that changes every cycle changes the visiting order from one step to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance enable |
| mask | input | N | Marked positions, bit i for position i |
| idx | output | ceil(log2 N) | Current index |
| valid | output | 1 | At least one mask bit is set |

## Verification
Two pairs of conditions can occur in the same cycle. The first is reset together with an advance under a full mask; the bench drives rst and adv high together, and the only correct result is index 0. The second is an advance requested in the same cycle the mask drops to zero; the bench expects the index to hold and valid to read 0 in that cycle. A reference model in the bench scans the ring position by position and predicts every step. It is run on a sequence of masks that changes every cycle and covers skips, wraps and the case where the current position is the only marked one.

// File: rtl/rr_mask_counter.sv
module rr_mask_counter #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic          valid
);

  logic [IW-1:0]  start;
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [IW-1:0]  off;
  logic [IW:0]    sum;
  logic [IW-1:0]  nxt;

  assign start = (idx == IW'(N-1)) ? '0 : idx + 1'b1;
  assign dbl   = {mask, mask};
  assign rot   = N'(dbl >> start);

  always_comb begin
    off = '0;
    for (int j = N-1; j >= 0; j--)
      if (rot[j]) off = IW'(j);
  end

  assign sum   = {1'b0, start} + {1'b0, off};
  assign nxt   = (sum >= (IW+1)'(N)) ? IW'(sum - (IW+1)'(N)) : IW'(sum);
  assign valid = |mask;

  always_ff @(posedge clk) begin
    if (rst)               idx <= '0;
    else if (adv && valid) idx <= nxt;
  end

  logic [N-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= mask;

  p_reset_r1: assert property (@(posedge clk) rst |=> idx == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> idx == $past(idx));

  p_land_marked_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && mask != '0) |=> mask_d[idx]);

  p_empty_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && mask == '0) |=> idx == $past(idx));

  p_single_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && $onehot(mask) && mask[idx]) |=> idx == $past(idx));

endmodule

// File: tb/rr_mask_counter_tb_top.sv
module rr_mask_counter_tb_top;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic [N-1:0] mask = '0;
  logic [IW-1:0] idx;
  logic valid;

  rr_mask_counter #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .adv(adv), .mask(mask), .idx(idx), .valid(valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int model_idx = 0;
  int q_idx[$];
  bit q_val[$];
  string q_tag[$];

  task automatic step(input bit r, input bit a, input logic [N-1:0] m, input string tag);
    @(negedge clk);
    rst = r; adv = a; mask = m;
    if (r) model_idx = 0;
    else if (a && m != '0) begin
      for (int k = 1; k <= N; k++) begin
        if (m[(model_idx + k) % N]) begin
          model_idx = (model_idx + k) % N;
          break;
        end
      end
    end
    q_idx.push_back(model_idx);
    q_val.push_back(m != '0);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (q_idx.size() > 0) begin
      automatic int e = q_idx.pop_front();
      automatic bit v = q_val.pop_front();
      automatic string t = q_tag.pop_front();
      checks++;
      if (idx !== IW'(e)) begin
        failures++;
        $display("FAIL %s idx actual=%0d expected=%0d", t, idx, e);
      end
      checks++;
      if (valid !== v) begin
        failures++;
        $display("FAIL R8 (%s) valid actual=%0b expected=%0b", t, valid, v);
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    step(1, 0, 8'h00, "R1");
    step(1, 1, 8'hFF, "R1");
    step(0, 0, 8'hFF, "R2");
    step(0, 0, 8'h5A, "R2");
    step(0, 1, 8'hFF, "R3");
    step(0, 1, 8'hFF, "R3");
    step(0, 1, 8'h22, "R4");
    step(0, 1, 8'h22, "R5");
    step(0, 1, 8'h00, "R7");
    step(0, 0, 8'h00, "R8");
    step(0, 1, 8'h02, "R6");
    step(0, 1, 8'h80, "R3");
    step(0, 1, 8'h01, "R5");
    step(0, 1, 8'h10, "R9");
    step(0, 1, 8'h08, "R9");
    step(0, 1, 8'h0C, "R9");
    step(0, 1, 8'hF0, "R9");
    step(0, 1, 8'hFF, "R3");
    step(1, 1, 8'hFF, "R1");
    lf = 8'hA7;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(0, (i % 5) != 4, (i % 7 == 3) ? 8'h00 : lf, "R9");
    end
    step(0, 0, 8'h00, "R2");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule